// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

The monitor watches each bus cycle and measures, in whole system clocks, how long the target takes to acknowledge it. If no qualifying acknowledge arrives within the selected limit, it raises a bus-error strobe. The strobe then stays high until the cycle ends.

An ordinary data access is ended only by the data-size acknowledge (`dsack`). An interrupt-acknowledge cycle is ended by either `dsack` or the autovector acknowledge (`avec`). A cycle to an internal target is always timed. A cycle that goes out to the external bus is timed only when all three of these hold:
- the CPU started it;
- it targets the external bus;
- the external-cycle enable is set.

Four limits are selectable through a 2-bit select. Parameters set the base limit and the select width. The limit select and the cycle attributes are taken on the first clock of each cycle, so later changes to them do not affect a cycle already running.

Top module: `bus_timeout_mon`

## Requirements
- R1: The limit select `tmo_sel` maps to a limit of 64 clocks for 0, 32 for 1, 16 for 2 and 8 for 3.
- R2: In a normal cycle (`cyc_iack` = 0), only `dsack` ends the timing. An `avec` pulse is ignored, and the bus error still fires at the limit.
- R3: In an interrupt-acknowledge cycle (`cyc_iack` = 1), either `dsack` or `avec` ends the timing, and no bus error follows.
- R4: With no qualifying acknowledge, `berr` goes high just after the L-th rising edge that samples `cyc_act` high, where L is the limit. It stays high while `cyc_act` stays high and clears on the first edge that samples `cyc_act` low.
- R5: A cycle with `tgt_ext` = 1 is timed only if `cpu_init` = 1 and `ext_en` = 1. Any other external cycle never raises `berr`. A cycle with `tgt_ext` = 0 is always timed.
- R6: Counting restarts for every cycle. A cycle begins at the first edge that samples `cyc_act` high after an edge that sampled it low. A cycle that ends before its limit leaves nothing behind for the next cycle.
- R7: `tmo_sel`, `cyc_iack`, `tgt_ext`, `cpu_init` and `ext_en` are taken on the first edge of a cycle. Changing `tmo_sel` later in the cycle does not change that cycle's limit.
- R8: A qualifying acknowledge sampled on the very edge at which the limit is reached counts as timely, and no bus error is raised. One sampled an edge later does not prevent the error.
- R9: While `rst` is high, and just after it, `berr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_act | input | 1 | Bus cycle in progress |
| cyc_iack | input | 1 | 1 = interrupt-acknowledge cycle, 0 = normal access |
| tgt_ext | input | 1 | Cycle goes out to the external bus |
| cpu_init | input | 1 | Cycle was started by the CPU |
| dsack | input | 1 | Data-size acknowledge |
| avec | input | 1 | Autovector acknowledge |
| tmo_sel | input | SEL_W | Timeout limit select |
| ext_en | input | 1 | Enable timing of external CPU cycles |
| berr | output | 1 | Bus error |

## Verification
Two events can land on the same clock: the limit being reached and the arrival of an acknowledge. The bench provokes this by driving the acknowledge so that it is sampled exactly on the L-th edge of a cycle, and again one edge later. It expects no error in the first case and an error from edge L in the second. A mid-cycle change of the limit select likewise competes with the captured limit. There the bench expects the error at the limit that was selected at the start of the cycle.

// File: rtl/bto_pkg.sv
package bto_pkg;
   // Limit in clocks for select value sel: the largest select gives base,
   // each step down doubles it.
   function automatic int unsigned bto_limit(input int unsigned base,
                                             input int unsigned sel,
                                             input int unsigned nsel);
      return base << (nsel - 1 - sel);
   endfunction
endpackage

// File: rtl/bto_qualify.sv
module bto_qualify (
   input  logic iack,
   input  logic tgt_ext,
   input  logic cpu_init,
   input  logic ext_en,
   input  logic dsack,
   input  logic avec,
   output logic timed,
   output logic ack_ok
);
   always_comb begin
      timed  = !tgt_ext || (cpu_init && ext_en);
      ack_ok = dsack || (iack && avec);
   end
endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
   parameter int unsigned BASE_CLKS = 8,
   parameter int unsigned SEL_W     = 2,
   localparam int unsigned NSEL     = 1 << SEL_W,
   localparam int unsigned MAX_LIM  = BASE_CLKS << (NSEL - 1),
   localparam int unsigned CNT_W    = $clog2(MAX_LIM + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   input  logic             iack_in,
   input  logic             timed_in,
   output logic [CNT_W-1:0] lim_eff,
   output logic             iack_eff,
   output logic             timed_eff
);
   import bto_pkg::*;

   logic [CNT_W-1:0] lim_tab [NSEL];
   logic [CNT_W-1:0] lim_q;
   logic             iack_q;
   logic             timed_q;

   for (genvar i = 0; i < NSEL; i++) begin : g_tab
      assign lim_tab[i] = CNT_W'(bto_limit(BASE_CLKS, i, NSEL));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lim_q   <= '0;
         iack_q  <= 1'b0;
         timed_q <= 1'b0;
      end else if (start) begin
         lim_q   <= lim_tab[sel];
         iack_q  <= iack_in;
         timed_q <= timed_in;
      end
   end

   always_comb begin
      lim_eff   = start ? lim_tab[sel] : lim_q;
      iack_eff  = start ? iack_in      : iack_q;
      timed_eff = start ? timed_in     : timed_q;
   end
endmodule

// File: rtl/bto_counter.sv
module bto_counter #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cyc_act,
   input  logic             timed,
   input  logic             ack_ok,
   input  logic [CNT_W-1:0] lim,
   output logic             busy,
   output logic             berr
);
   logic             busy_q;
   logic             run_q;
   logic             berr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   assign cnt_nx = cnt_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst || !cyc_act) begin
         busy_q <= 1'b0;
         run_q  <= 1'b0;
         berr_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         busy_q <= 1'b1;
         run_q  <= timed && !ack_ok;
         cnt_q  <= CNT_W'(1);
      end else if (run_q) begin
         if (ack_ok) begin
            run_q <= 1'b0;
         end else if (cnt_nx == lim) begin
            berr_q <= 1'b1;
            run_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_nx;
         end
      end
   end

   assign busy = busy_q;
   assign berr = berr_q;
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
   parameter int unsigned BASE_CLKS = 8,
   parameter int unsigned SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cyc_act,
   input  logic             cyc_iack,
   input  logic             tgt_ext,
   input  logic             cpu_init,
   input  logic             dsack,
   input  logic             avec,
   input  logic [SEL_W-1:0] tmo_sel,
   input  logic             ext_en,
   output logic             berr
);
   localparam int unsigned NSEL    = 1 << SEL_W;
   localparam int unsigned MAX_LIM = BASE_CLKS << (NSEL - 1);
   localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

   initial begin
      assert (BASE_CLKS >= 2) else $error("BASE_CLKS must be at least 2");
      assert (SEL_W >= 1 && SEL_W <= 3) else $error("SEL_W out of range");
   end

   logic             busy;
   logic             start;
   logic             timed_now;
   logic             ack_unused;
   logic             iack_eff;
   logic             timed_eff;
   logic             ack_ok;
   logic             timed_unused;
   logic [CNT_W-1:0] lim_eff;

   assign start = cyc_act && !busy;

   bto_qualify u_live (
      .iack     (cyc_iack),
      .tgt_ext  (tgt_ext),
      .cpu_init (cpu_init),
      .ext_en   (ext_en),
      .dsack    (dsack),
      .avec     (avec),
      .timed    (timed_now),
      .ack_ok   (ack_unused)
   );

   bto_capture #(.BASE_CLKS(BASE_CLKS), .SEL_W(SEL_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .sel       (tmo_sel),
      .iack_in   (cyc_iack),
      .timed_in  (timed_now),
      .lim_eff   (lim_eff),
      .iack_eff  (iack_eff),
      .timed_eff (timed_eff)
   );

   bto_qualify u_ack (
      .iack     (iack_eff),
      .tgt_ext  (1'b0),
      .cpu_init (1'b0),
      .ext_en   (1'b0),
      .dsack    (dsack),
      .avec     (avec),
      .timed    (timed_unused),
      .ack_ok   (ack_ok)
   );

   bto_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .cyc_act (cyc_act),
      .timed   (timed_eff),
      .ack_ok  (ack_ok),
      .lim     (lim_eff),
      .busy    (busy),
      .berr    (berr)
   );
endmodule

// File: rtl/bus_timeout_mon_chk.sv
module bus_timeout_mon_chk #(
   parameter int unsigned BASE_CLKS = 8,
   parameter int unsigned SEL_W     = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             cyc_act,
   input logic             cyc_iack,
   input logic             tgt_ext,
   input logic             cpu_init,
   input logic             dsack,
   input logic             avec,
   input logic [SEL_W-1:0] tmo_sel,
   input logic             ext_en,
   input logic             berr
);
   logic        act_q;
   logic        untimed_q;
   logic [15:0] elapsed_q;

   always_ff @(posedge clk) begin
      if (rst || !cyc_act) begin
         act_q     <= 1'b0;
         untimed_q <= 1'b0;
         elapsed_q <= '0;
      end else if (!act_q) begin
         act_q     <= 1'b1;
         untimed_q <= tgt_ext && !(cpu_init && ext_en);
         elapsed_q <= 16'd1;
      end else if (elapsed_q != 16'hFFFF) begin
         elapsed_q <= elapsed_q + 16'd1;
      end
   end

   // R4: the error clears once the cycle ends
   p_clear_on_idle_r4: assert property (@(posedge clk) disable iff (rst)
      !cyc_act |=> !berr);

   // R4: the error holds while the cycle is still running
   p_hold_while_active_r4: assert property (@(posedge clk) disable iff (rst)
      (berr && cyc_act) |=> berr);

   // R1: never earlier than the smallest limit
   p_min_latency_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(berr) |-> (elapsed_q >= 16'(BASE_CLKS)));

   // R5: untimed external cycles stay free of errors
   p_untimed_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      untimed_q |-> !berr);

   // R6: an error needs a running cycle
   p_needs_cycle_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(berr) |-> act_q);
endmodule

bind bus_timeout_mon bus_timeout_mon_chk #(.BASE_CLKS(BASE_CLKS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/bus_timeout_mon_test.sv
`timescale 1ns/1ps
module bus_timeout_mon_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cyc_act = 1'b0;
   logic       cyc_iack = 1'b0;
   logic       tgt_ext = 1'b0;
   logic       cpu_init = 1'b0;
   logic       dsack = 1'b0;
   logic       avec = 1'b0;
   logic [1:0] tmo_sel = 2'd0;
   logic       ext_en = 1'b0;
   logic       berr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit    exp;
      string req;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   bus_timeout_mon uut (
      .clk(clk), .rst(rst), .cyc_act(cyc_act), .cyc_iack(cyc_iack),
      .tgt_ext(tgt_ext), .cpu_init(cpu_init), .dsack(dsack), .avec(avec),
      .tmo_sel(tmo_sel), .ext_en(ext_en), .berr(berr)
   );

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (berr !== it.exp) begin
            errors++;
            $display("FAIL %s berr=%0b expected %0b at %0t", it.req, berr, it.exp, $time);
         end
      end
   end

   task automatic run_cyc(input string req, input bit iack, input bit ext,
                          input bit cpu, input bit en, input logic [1:0] sel,
                          input int ack_at, input bit use_avec,
                          input int len, input bit chg_sel);
      int lim   = 8 << (3 - sel);
      bit timed = !ext || (cpu && en);
      bit qual  = (ack_at > 0) && (!use_avec || iack);
      bit fire  = timed && !(qual && ack_at <= lim) && (len >= lim);
      @(posedge clk);
      #1;
      cyc_act  = 1'b1;
      cyc_iack = iack;
      tgt_ext  = ext;
      cpu_init = cpu;
      ext_en   = en;
      tmo_sel  = sel;
      for (int k = 1; k <= len; k++) begin
         dsack = (k == ack_at) && !use_avec;
         avec  = (k == ack_at) && use_avec;
         if (chg_sel && k == 2) tmo_sel = ~sel;
         @(posedge clk);
         sb.push_back('{fire && (k >= lim), req});
         #1;
      end
      cyc_act = 1'b0;
      dsack   = 1'b0;
      avec    = 1'b0;
      @(posedge clk);
      sb.push_back('{1'b0, req});
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (berr !== 1'b0) begin
         errors++;
         $display("FAIL R9 berr=%0b expected 0 in reset", berr);
      end
      rst = 1'b0;
      @(posedge clk);
      #1;
      checks++;
      if (berr !== 1'b0) begin
         errors++;
         $display("FAIL R9 berr=%0b expected 0 after reset", berr);
      end
      // R1 and R4: each limit, no acknowledge
      run_cyc("R1 sel3", 0, 0, 0, 0, 2'd3, 0, 0, 12, 0);
      run_cyc("R1 sel2", 0, 0, 0, 0, 2'd2, 0, 0, 19, 0);
      run_cyc("R1 sel1", 0, 0, 0, 0, 2'd1, 0, 0, 35, 0);
      run_cyc("R4 sel0", 0, 0, 0, 0, 2'd0, 0, 0, 67, 0);
      // R2: normal cycle
      run_cyc("R2 dsack", 0, 0, 0, 0, 2'd3, 5, 0, 12, 0);
      run_cyc("R2 avec ignored", 0, 0, 0, 0, 2'd3, 5, 1, 12, 0);
      // R3: interrupt acknowledge
      run_cyc("R3 avec", 1, 0, 0, 0, 2'd3, 5, 1, 12, 0);
      run_cyc("R3 dsack", 1, 0, 0, 0, 2'd2, 9, 0, 20, 0);
      // R8: acknowledge on the limit edge, and one edge late
      run_cyc("R8 on limit", 0, 0, 0, 0, 2'd3, 8, 0, 12, 0);
      run_cyc("R8 late", 0, 0, 0, 0, 2'd3, 9, 0, 12, 0);
      run_cyc("R8 iack on limit", 1, 0, 0, 0, 2'd2, 16, 1, 20, 0);
      // R5: external qualification
      run_cyc("R5 ext disabled", 0, 1, 1, 0, 2'd3, 0, 0, 12, 0);
      run_cyc("R5 ext enabled", 0, 1, 1, 1, 2'd3, 0, 0, 12, 0);
      run_cyc("R5 ext not cpu", 0, 1, 0, 1, 2'd3, 0, 0, 12, 0);
      run_cyc("R5 internal", 0, 0, 0, 0, 2'd3, 0, 0, 10, 0);
      // R7: select changed mid-cycle
      run_cyc("R7 sel3 to 0", 0, 0, 0, 0, 2'd3, 0, 0, 12, 1);
      run_cyc("R7 sel0 to 3", 0, 0, 0, 0, 2'd0, 0, 0, 20, 1);
      // R6: short cycles do not accumulate
      run_cyc("R6 short a", 0, 0, 0, 0, 2'd3, 0, 0, 7, 0);
      run_cyc("R6 short b", 0, 0, 0, 0, 2'd3, 0, 0, 7, 0);
      run_cyc("R6 fresh", 0, 0, 0, 0, 2'd3, 0, 0, 9, 0);
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule